// File: doc/BRIEF.md
# SPI Clock and Chip-Select Timing Generator

This block sequences the serial clock and the chip-select framing of an SPI master that talks to several target devices. Each target owns a 32-bit timing word and a pair of clock-mode bits (polarity and phase). The timing word sets the bit rate as a power-of-two fraction of the reference clock. It also sets how long the select is held before the first clock edge, how long it is held after the last edge, and how long the select must then stay released. The data shifter and the FIFOs sit outside this block. They follow the one-cycle `shift_stb` and `sample_stb` pulses, which line up with the clock edges on which data must change and be captured.

A frame starts with a one-cycle `start_req` while the block is idle. At that moment the target index, its timing word and its mode bits are captured. The frame then clocks whole bits until a stop request has been seen. It ends on the trailing edge of the bit in progress, so every frame carries at least one bit. Between frames the serial clock rests at the polarity level of the currently selected target.

Top module: `spi_sclk_cs_gen`

## Requirements
- R1: The half-period of the serial clock is 256/P reference cycles. P is the highest set bit of the 8-bit rate code, and a code of zero counts as 1. A code of 128 or above therefore gives a 4-cycle bit, and a code of 0 or 1 gives a 512-cycle bit.
- R2: The timing word of target n sits at bits [32n+31:32n] of `dev_param`. Within that word, bits 31:24 hold the rate code, bits 23:16 the setup count S, bits 15:8 the hold count Hd and bits 7:0 the release count D.
- R3: A start that is accepted drives exactly one `cs_n` bit low, the one for the chosen target, in the next cycle. The first clock edge follows S+1 reference cycles after that select edge.
- R4: While the block is idle, `sclk` takes the polarity bit of the target chosen by `dev_sel` one cycle later. During a frame it rests at the captured polarity and leaves it on each leading edge.
- R5: With phase 0, `sample_stb` pulses on leading edges and `shift_stb` pulses on trailing edges. With phase 1, the two are swapped. Each strobe lasts one cycle, in the same cycle that `sclk` changes.
- R6: A stop request seen during setup, or at any cycle up to and including the cycle of a trailing edge, ends the frame on that bit's trailing edge. Stop requests outside a frame have no effect.
- R7: `cs_n` returns high Hd+1 cycles after the final trailing edge, with `sclk` at rest throughout.
- R8: `busy` stays high for D+1 cycles after the select is released. A start request while `busy` is high is ignored.
- R9: A start with `dev_sel` equal to or above the number of targets is ignored.
- R10: After reset, all `cs_n` bits are high, `sclk` and both strobes are low, and `busy` is low.
- R11: Changes to `dev_sel`, `dev_param` or the mode bits during a frame do not affect that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_param | input | 32*NUM_CS | Per-target timing words |
| cs_cpol | input | NUM_CS | Per-target clock polarity |
| cs_cpha | input | NUM_CS | Per-target clock phase |
| dev_sel | input | SEL_W | Target index for the next frame |
| start_req | input | 1 | Begin a frame (accepted only when idle) |
| stop_req | input | 1 | End the frame after the current bit |
| sclk | output | 1 | Serial clock |
| cs_n | output | NUM_CS | Active-low chip selects |
| shift_stb | output | 1 | Data-change strobe |
| sample_stb | output | 1 | Data-capture strobe |
| busy | output | 1 | Frame or release interval in progress |

## Verification
The bench targets the two rate extremes, a zero rate code and a rate code with several bits set. A design that mishandles these clocks at the wrong speed or divides by zero. It aims stop requests at setup, at mid-bit and at the trailing-edge cycle. An off-by-one there would clock one bit too many or cut a bit in half. It issues starts while busy, starts with an out-of-range index and starts held high across frame ends. A faulty block would reselect a target early, shorten the release gap or drive a select that does not exist. It also changes the settings in the middle of a frame, which catches a design that reads its timing word live rather than the one captured at start.

// File: rtl/spi_tg_pkg.sv
package spi_tg_pkg;
  localparam int FLD_W = 8;
  localparam int PW_W  = 32;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_LEAD, ST_TRAIL, ST_HOLD, ST_GAP
  } tg_state_e;

  // Field order is decoded by position: rate 31:24, setup 23:16, hold 15:8, release 7:0
  typedef struct packed {
    logic [FLD_W-1:0] rate;
    logic [FLD_W-1:0] setup;
    logic [FLD_W-1:0] hold;
    logic [FLD_W-1:0] gap;
  } dev_param_t;
endpackage

// File: rtl/spi_tg_rate_decode.sv
module spi_tg_rate_decode
  import spi_tg_pkg::*;
#(
  parameter int CODE_W = FLD_W
) (
  input  logic [CODE_W-1:0] rate_code,
  output logic [CODE_W-1:0] half_m1
);
  localparam int IDX_W = $clog2(CODE_W);

  logic [IDX_W-1:0] msb;
  logic [CODE_W:0]  half_full;
  logic [CODE_W:0]  half_dec;

  // Highest set bit wins; an all-zero code falls back to index 0
  always_comb begin
    msb = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (rate_code[i]) msb = IDX_W'(i);
    end
  end

  assign half_full = {1'b1, {CODE_W{1'b0}}} >> msb;
  assign half_dec  = half_full - 1'b1;
  assign half_m1   = half_dec[CODE_W-1:0];

  always_comb begin
    AST_HALF_NONZERO: assert (half_full >= 2); // R1
  end
endmodule

// File: rtl/spi_tg_param_sel.sv
module spi_tg_param_sel
  import spi_tg_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int SEL_W  = 3
) (
  input  logic [NUM_CS*PW_W-1:0] dev_param,
  input  logic [NUM_CS-1:0]      cs_cpol,
  input  logic [NUM_CS-1:0]      cs_cpha,
  input  logic [SEL_W-1:0]       sel,
  output dev_param_t             sel_word,
  output logic                   sel_cpol,
  output logic                   sel_cpha,
  output logic                   sel_ok
);
  dev_param_t words [NUM_CS];

  for (genvar g = 0; g < NUM_CS; g++) begin : g_unpack
    assign words[g] = dev_param[g*PW_W +: PW_W];
  end

  assign sel_ok = ({1'b0, sel} < (SEL_W+1)'(NUM_CS));

  always_comb begin
    sel_word = '0;
    sel_cpol = 1'b0;
    sel_cpha = 1'b0;
    for (int i = 0; i < NUM_CS; i++) begin
      if (sel == SEL_W'(i)) begin
        sel_word = words[i];
        sel_cpol = cs_cpol[i];
        sel_cpha = cs_cpha[i];
      end
    end
  end
endmodule

// File: rtl/spi_tg_cs_drive.sv
module spi_tg_cs_drive #(
  parameter int NUM_CS = 5,
  parameter int SEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              release_all,
  input  logic [SEL_W-1:0]  sel,
  output logic [NUM_CS-1:0] cs_n
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    always_ff @(posedge clk) begin
      if (rst)              cs_n[g] <= 1'b1;
      else if (take)        cs_n[g] <= (sel != SEL_W'(g));
      else if (release_all) cs_n[g] <= 1'b1;
    end
  end

  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n)); // R3
endmodule

// File: rtl/spi_sclk_cs_gen.sv
module spi_sclk_cs_gen
  import spi_tg_pkg::*;
#(
  parameter int NUM_CS = 5,
  parameter int SEL_W  = 3
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_CS*PW_W-1:0] dev_param,
  input  logic [NUM_CS-1:0]      cs_cpol,
  input  logic [NUM_CS-1:0]      cs_cpha,
  input  logic [SEL_W-1:0]       dev_sel,
  input  logic                   start_req,
  input  logic                   stop_req,
  output logic                   sclk,
  output logic [NUM_CS-1:0]      cs_n,
  output logic                   shift_stb,
  output logic                   sample_stb,
  output logic                   busy
);
  localparam int CNT_W = FLD_W;

  tg_state_e        state;
  logic [CNT_W-1:0] cnt;
  dev_param_t       cfg_q;
  logic             cpol_q, cpha_q, stop_pend;
  logic             sclk_q, shift_q, sample_q;

  dev_param_t       sel_word;
  logic             sel_cpol, sel_cpha, sel_ok;
  logic [CNT_W-1:0] half_m1;
  logic             take, release_all, in_bits, accept;

  spi_tg_param_sel #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_sel (
    .dev_param(dev_param), .cs_cpol(cs_cpol), .cs_cpha(cs_cpha), .sel(dev_sel),
    .sel_word(sel_word), .sel_cpol(sel_cpol), .sel_cpha(sel_cpha), .sel_ok(sel_ok)
  );

  spi_tg_rate_decode #(.CODE_W(FLD_W)) u_rate (
    .rate_code(cfg_q.rate), .half_m1(half_m1)
  );

  assign accept      = (state == ST_IDLE) && start_req && sel_ok;
  assign take        = accept;
  assign release_all = (state == ST_HOLD) && (cnt == '0);
  assign in_bits     = (state == ST_SETUP) || (state == ST_LEAD) || (state == ST_TRAIL);

  spi_tg_cs_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) u_cs (
    .clk(clk), .rst(rst), .take(take), .release_all(release_all),
    .sel(dev_sel), .cs_n(cs_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cfg_q     <= '0;
      cpol_q    <= 1'b0;
      cpha_q    <= 1'b0;
      stop_pend <= 1'b0;
      sclk_q    <= 1'b0;
      shift_q   <= 1'b0;
      sample_q  <= 1'b0;
    end else begin
      shift_q  <= 1'b0;
      sample_q <= 1'b0;
      if (stop_req && in_bits) stop_pend <= 1'b1;
      unique case (state)
        ST_IDLE: begin
          if (sel_ok) sclk_q <= sel_cpol;
          if (accept) begin
            state     <= ST_SETUP;
            cnt       <= sel_word.setup;
            cfg_q     <= sel_word;
            cpol_q    <= sel_cpol;
            cpha_q    <= sel_cpha;
            stop_pend <= 1'b0;
          end
        end
        ST_SETUP, ST_TRAIL: begin
          if (cnt == '0) begin
            state    <= ST_LEAD;
            cnt      <= half_m1;
            sclk_q   <= ~cpol_q;
            sample_q <= ~cpha_q;
            shift_q  <= cpha_q;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_LEAD: begin
          if (cnt == '0) begin
            sclk_q   <= cpol_q;
            sample_q <= cpha_q;
            shift_q  <= ~cpha_q;
            if (stop_pend || stop_req) begin
              state <= ST_HOLD;
              cnt   <= cfg_q.hold;
            end else begin
              state <= ST_TRAIL;
              cnt   <= half_m1;
            end
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == '0) begin
            state <= ST_GAP;
            cnt   <= cfg_q.gap;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (cnt == '0) state <= ST_IDLE;
          else           cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign sclk       = sclk_q;
  assign shift_stb  = shift_q;
  assign sample_stb = sample_q;
  assign busy       = (state != ST_IDLE);

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(shift_stb && sample_stb)); // R5
  AST_STROBE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    (shift_stb || sample_stb) |-> (sclk != $past(sclk))); // R5
  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (&cs_n)); // R8
  AST_SELECT_FROM_IDLE: assert property (@(posedge clk) disable iff (rst)
    $fell(&cs_n) |-> $past(!busy)); // R8
  AST_HOLD_AT_REST: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD) |-> (sclk == cpol_q)); // R7
endmodule

// File: tb/tb_spi_sclk_cs_gen.sv
`timescale 1ns/1ps
module tb_spi_sclk_cs_gen;
  localparam int NUM_CS = 5;
  localparam int SEL_W  = 3;
  localparam int LIMIT  = 150000;
  localparam int K_LEAD = 0, K_TRAIL = 1, K_REL = 2, K_FREE = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NUM_CS*32-1:0] dev_param = '0;
  logic [NUM_CS-1:0] cs_cpol = '0, cs_cpha = '0;
  logic [SEL_W-1:0] dev_sel = '0;
  logic start_req = 1'b0, stop_req = 1'b0;
  logic sclk, shift_stb, sample_stb, busy;
  logic [NUM_CS-1:0] cs_n;

  spi_sclk_cs_gen #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) dut (
    .clk(clk), .rst(rst), .dev_param(dev_param), .cs_cpol(cs_cpol), .cs_cpha(cs_cpha),
    .dev_sel(dev_sel), .start_req(start_req), .stop_req(stop_req), .sclk(sclk),
    .cs_n(cs_n), .shift_stb(shift_stb), .sample_stb(sample_stb), .busy(busy)
  );

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;
  string cur_tag = "R10 reset";

  // behavioural reference: event times rather than counters
  int m_busy, m_cs, m_sclk, m_shift, m_sample, m_stop, m_next, m_kind;
  int m_cpol, m_cpha, m_H, m_hold, m_gap;

  function automatic int half_of(int code);
    int p = 1;
    for (int v = 128; v >= 1; v = v / 2) if ((code & v) != 0 && p == 1) p = v;
    return 256 / p;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_busy = 0; m_cs = -1; m_sclk = 0; m_shift = 0; m_sample = 0; m_stop = 0;
      m_next = 0; m_kind = K_FREE;
    end else begin
      m_shift = 0; m_sample = 0;
      if (m_busy == 0) begin
        if (int'(dev_sel) < NUM_CS) begin
          m_sclk = cs_cpol[dev_sel];
          if (start_req) begin
            logic [31:0] w;
            w = dev_param[int'(dev_sel)*32 +: 32];
            m_busy = 1; m_cs = int'(dev_sel); m_cpol = cs_cpol[dev_sel];
            m_cpha = cs_cpha[dev_sel]; m_H = half_of(int'(w[31:24]));
            m_hold = int'(w[15:8]); m_gap = int'(w[7:0]);
            m_next = cyc + int'(w[23:16]) + 1; m_kind = K_LEAD; m_stop = 0;
          end
        end
      end else begin
        if (stop_req && (m_kind == K_LEAD || m_kind == K_TRAIL)) m_stop = 1;
        if (cyc == m_next) begin
          case (m_kind)
            K_LEAD: begin
              m_sclk = 1 - m_cpol; m_sample = 1 - m_cpha; m_shift = m_cpha;
              m_next = cyc + m_H; m_kind = K_TRAIL;
            end
            K_TRAIL: begin
              m_sclk = m_cpol; m_sample = m_cpha; m_shift = 1 - m_cpha;
              if (m_stop != 0) begin m_next = cyc + m_hold + 1; m_kind = K_REL; end
              else begin m_next = cyc + m_H; m_kind = K_LEAD; end
            end
            K_REL: begin m_cs = -1; m_next = cyc + m_gap + 1; m_kind = K_FREE; end
            default: m_busy = 0;
          endcase
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [NUM_CS-1:0] exp_cs;
      bit ok;
      exp_cs = '1;
      if (m_cs >= 0) exp_cs[m_cs] = 1'b0;
      ok = (int'(sclk) == m_sclk) && (cs_n == exp_cs) && (int'(shift_stb) == m_shift)
           && (int'(sample_stb) == m_sample) && (int'(busy) == m_busy);
      tests++;
      if (!ok) begin
        fails++;
        $display("FAIL %s cyc=%0d sclk %0d/%0d cs_n %b/%b shift %0d/%0d sample %0d/%0d busy %0d/%0d (actual/expected)",
                 cur_tag, cyc, sclk, m_sclk, cs_n, exp_cs, shift_stb, m_shift,
                 sample_stb, m_sample, busy, m_busy);
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > LIMIT && !done) begin
      done = 1;
      fails++; tests++;
      $display("FAIL watchdog expired at cycle %0d actual=1 expected=0", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_dev(int n, int rate, int su, int hd, int gp, bit pol, bit pha);
    dev_param[n*32 +: 32] = {8'(rate), 8'(su), 8'(hd), 8'(gp)};
    cs_cpol[n] = pol;
    cs_cpha[n] = pha;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4000 && busy; i++) @(negedge clk);
  endtask

  task automatic frame(int sel, int stop_wait);
    dev_sel = SEL_W'(sel);
    start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(stop_wait);
    stop_req = 1'b1; tick(1); stop_req = 1'b0;
    wait_idle();
    tick(2);
  endtask

  initial begin
    set_dev(0, 128, 0, 0, 0, 1'b0, 1'b0);
    set_dev(1, 1,   3, 2, 4, 1'b1, 1'b1);
    set_dev(2, 0,   0, 1, 1, 1'b0, 1'b1);
    set_dev(3, 8'h60, 5, 7, 9, 1'b1, 1'b0);
    set_dev(4, 8'hFF, 1, 1, 2, 1'b0, 1'b1);
    tick(4);
    rst = 1'b0;
    tick(1);
    // R10: reset state seen at the ports before any frame
    chk(cs_n == '1, "R10", "cs_n all high", int'(cs_n), (1 << NUM_CS) - 1);
    chk(busy == 1'b0, "R10", "busy", int'(busy), 0);
    chk(!shift_stb && !sample_stb, "R10", "strobes", int'(shift_stb) + int'(sample_stb), 0);

    cur_tag = "R1/R2/R3/R4/R5/R6/R7/R8 sweep";
    for (int d = 0; d < NUM_CS; d++) begin
      frame(d, 0);
      frame(d, 3);
      frame(d, 17);
    end
    frame(0, 40);
    frame(4, 25);

    cur_tag = "R6 stop during setup";
    frame(3, 1);
    cur_tag = "R6 stop at each offset";
    for (int k = 4; k < 16; k++) frame(4, k);

    cur_tag = "R8 start while busy";
    dev_sel = 3'd3; start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(6);
    dev_sel = 3'd0; start_req = 1'b1; tick(3); start_req = 1'b0;
    chk(cs_n[0] == 1'b1, "R8", "start while busy reselected", int'(cs_n[0]), 1);
    tick(20); stop_req = 1'b1; tick(1); stop_req = 1'b0;
    tick(3); start_req = 1'b1; tick(2); start_req = 1'b0;
    wait_idle(); tick(2);

    cur_tag = "R8 back-to-back minimum gap";
    dev_sel = 3'd4; start_req = 1'b1; stop_req = 1'b1;
    tick(60);
    start_req = 1'b0; stop_req = 1'b0;
    wait_idle(); tick(2);

    cur_tag = "R9 out-of-range target";
    dev_sel = 3'd6; start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(3);
    chk(busy == 1'b0, "R9", "busy after bad index", int'(busy), 0);
    chk(cs_n == '1, "R9", "cs_n after bad index", int'(cs_n), (1 << NUM_CS) - 1);
    dev_sel = 3'd7; start_req = 1'b1; tick(2); start_req = 1'b0; tick(2);
    chk(busy == 1'b0, "R9", "busy after index 7", int'(busy), 0);

    cur_tag = "R4 idle level follows selection";
    dev_sel = 3'd1; tick(2);
    chk(sclk == 1'b1, "R4", "idle sclk for polarity-1 target", int'(sclk), 1);
    dev_sel = 3'd0; tick(2);
    chk(sclk == 1'b0, "R4", "idle sclk for polarity-0 target", int'(sclk), 0);

    cur_tag = "R11 settings changed mid-frame";
    dev_sel = 3'd3; start_req = 1'b1; tick(1); start_req = 1'b0;
    tick(8);
    set_dev(3, 128, 0, 0, 0, 1'b0, 1'b1);
    dev_sel = 3'd1;
    tick(30); stop_req = 1'b1; tick(1); stop_req = 1'b0;
    wait_idle(); tick(2);
    set_dev(3, 8'h60, 5, 7, 9, 1'b1, 1'b0);
    frame(3, 10);

    cur_tag = "R6 stop while idle";
    stop_req = 1'b1; tick(3); stop_req = 1'b0;
    chk(busy == 1'b0, "R6", "stop while idle", int'(busy), 0);
    frame(0, 12);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule